// File: doc/BRIEF.md
# Flash Instruction Prefetch Buffer Controller

This block sits between a processor's instruction fetch port and a slow flash read port. It keeps a small set of line buffers, each holding one aligned line of consecutive flash words together with a line tag and a valid flag. A fetch that matches a valid buffer is answered from the buffer one cycle later without touching flash. A fetch that misses claims the least recently used buffer and reads the whole aligned line from flash one word at a time. The requested word goes back to the processor as soon as it arrives, while the rest of the line keeps loading.

When a fetch targets a word late in its line, the controller fills the following sequential line ahead of time, so straight-line code keeps hitting. While such an ahead-of-time fill runs, fetches that hit are still served; fetches that miss wait until the fill ends. A configuration write port can force the buffers on or off and clear every tag. An event input vector invalidates all lines on system conditions that make buffered code stale. With the buffers off, each fetch becomes a single direct flash read.

Top module: `pfb_flash_prefetch`

## Requirements
- R1: After reset the buffers are enabled (`pf_active`=1), `cpu_ready` and `fl_rd` are low, and no buffer holds a valid line.
- R2: A fetch that matches a valid line while enabled is answered with `cpu_ready` high for exactly one cycle, in the cycle after acceptance, with the buffered word, and issues no flash read.
- R3: On a miss the aligned line (tag = address with the low 3 word-index bits removed) is read as 8 flash reads in ascending order from word 0, with one read outstanding at a time. The target word is returned in the cycle after its flash data arrives. The line becomes valid only after word 7 is written.
- R4: A fetch whose word index is 3 to 7 (hit or miss) causes the next sequential line to be filled, if it is not already valid, right after any demand fill. A fetch whose word index is 0 to 2 does not.
- R5: During an ahead-of-time fill, fetches that hit a valid line are served. A fetch to a line that is not valid, including the line being filled, waits until that fill completes.
- R6: A new line goes into the least recently used buffer. Both a hit and the start of a fill make that buffer the most recently used.
- R7: Any configuration write clears every valid flag, whatever its force bits. This includes a write with no force bit set, which is the clear-tags command. A line whose fill was in progress at an invalidation does not become valid.
- R8: A one-cycle pulse on any `inv_evt` bit clears every valid flag. The bits are 0 ROM access, 1 instruction fetch error, 2 system abort, 3 mirror mode change.
- R9: A force-on or force-off write changes `pf_active` only once no flash operation or fill is in progress. When the controller is idle, the change shows in the next cycle. Force-off wins when both bits are written together.
- R10: While disabled, each fetch makes exactly one flash read of the addressed word and returns it in the cycle after the data arrives. No buffer is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| cpu_valid | input | 1 | Fetch request, held until `cpu_ready` |
| cpu_addr | input | ADDR_W | Fetch word address |
| cpu_ready | output | 1 | One-cycle response strobe |
| cpu_rdata | output | DATA_W | Fetched word, valid with `cpu_ready` |
| fl_rd | output | 1 | One-cycle flash read request |
| fl_addr | output | ADDR_W | Flash word address for the request |
| fl_rvalid | input | 1 | Flash read data strobe |
| fl_rdata | input | DATA_W | Flash read data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_force_on | input | 1 | Write data: enable buffers |
| cfg_force_off | input | 1 | Write data: disable buffers |
| inv_evt | input | EVT_W | Invalidate-all event pulses |
| pf_active | output | 1 | Current buffer enable state |

## Verification
The bench times each fetch from acceptance to response. This separates a hit (one cycle) from a miss on word k ((k+1)·(LAT+1)+1 cycles), so a wrong replacement victim, a missing or spurious ahead-of-time fill, or a line marked valid too early shows up as a latency off by many cycles. It invalidates a line in the middle of its own fill: a design that ignores this would later serve that line as a hit. It writes force-off during a fill and checks that `pf_active` stays high until the fill ends; a design that switches at once would lose the remaining words. Flash read counts expose hits that go to flash and disabled fetches that load buffers.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
  // Controller sequencing states
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,  // waiting for a fetch
    S_FILL = 2'd1,  // streaming a line from flash
    S_ARM  = 2'd2,  // deciding on a next-line fill
    S_DIR  = 2'd3   // single direct read, buffers off
  } pfb_state_e;

  // Event vector bit positions
  localparam int EVT_ROM    = 0;
  localparam int EVT_FETERR = 1;
  localparam int EVT_ABORT  = 2;
  localparam int EVT_MIRROR = 3;
endpackage

// File: rtl/pfb_lru.sv
module pfb_lru #(
  parameter int NUM_BUF = 4,
  localparam int IW = $clog2(NUM_BUF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          touch_en,
  input  logic [IW-1:0] touch_idx,
  output logic [IW-1:0] victim
);
  // Each entry holds its recency rank: 0 newest, NUM_BUF-1 oldest.
  logic [IW-1:0]      age_q [NUM_BUF];
  logic [IW-1:0]      age_n [NUM_BUF];
  logic [NUM_BUF-1:0] is_old;

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_rank
    always_comb begin
      age_n[g] = age_q[g];
      if (touch_idx == IW'(g))
        age_n[g] = '0;
      else if (age_q[g] < age_q[touch_idx])
        age_n[g] = age_q[g] + IW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        age_q[g] <= IW'(g);
      else if (touch_en) age_q[g] <= age_n[g];
    end

    assign is_old[g] = (age_q[g] == IW'(NUM_BUF - 1));
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < NUM_BUF; i++)
      if (is_old[i]) victim = IW'(i);
  end

  // R6
  single_oldest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(is_old) == 1);
endmodule

// File: rtl/pfb_line_store.sv
module pfb_line_store #(
  parameter int NUM_BUF = 4,
  parameter int WORDS   = 8,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 13,
  localparam int IW = $clog2(NUM_BUF),
  localparam int WW = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TAG_W-1:0]  lk_tag,
  input  logic [WW-1:0]     lk_word,
  input  logic [TAG_W-1:0]  nx_tag,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_buf,
  input  logic [WW-1:0]     wr_word,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              alloc_en,
  input  logic [IW-1:0]     alloc_buf,
  input  logic [TAG_W-1:0]  alloc_tag,
  input  logic              seal_en,
  input  logic [IW-1:0]     seal_buf,
  input  logic              inv_all,
  output logic              hit,
  output logic [IW-1:0]     hit_buf,
  output logic [DATA_W-1:0] hit_data,
  output logic              nx_hit
);
  logic [DATA_W-1:0]  mem_q [NUM_BUF*WORDS];
  logic [TAG_W-1:0]   tag_q [NUM_BUF];
  logic               vld_q [NUM_BUF];
  logic [NUM_BUF-1:0] vld_vec, match, nmatch;

  // Line data: no reset needed, guarded by the valid flags.
  always_ff @(posedge clk) begin
    if (wr_en) mem_q[{wr_buf, wr_word}] <= wr_data;
  end

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_line
    logic vld_n;
    always_comb begin
      vld_n = vld_q[g];
      if (inv_all)                                  vld_n = 1'b0;
      else if (alloc_en && alloc_buf == IW'(g))     vld_n = 1'b0;
      else if (seal_en && seal_buf == IW'(g))       vld_n = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g] <= 1'b0;
        tag_q[g] <= '0;
      end else begin
        vld_q[g] <= vld_n;
        if (alloc_en && alloc_buf == IW'(g)) tag_q[g] <= alloc_tag;
      end
    end

    assign vld_vec[g] = vld_q[g];
    assign match[g]   = vld_q[g] && (tag_q[g] == lk_tag);
    assign nmatch[g]  = vld_q[g] && (tag_q[g] == nx_tag);
  end

  always_comb begin
    hit_buf = '0;
    for (int i = 0; i < NUM_BUF; i++)
      if (match[i]) hit_buf = IW'(i);
  end

  assign hit      = |match;
  assign nx_hit   = |nmatch;
  assign hit_data = mem_q[{hit_buf, lk_word}];

  // R6
  unique_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  // R7
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_vec == '0));
endmodule

// File: rtl/pfb_flash_prefetch.sv
module pfb_flash_prefetch
  import pfb_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 32,
  parameter int NUM_BUF     = 4,
  parameter int LINE_WORDS  = 8,
  parameter int EARLY_IDX   = 3,
  parameter int EVT_W       = 4,
  parameter bit EN_AT_RESET = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_valid,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              fl_rd,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic              fl_rvalid,
  input  logic [DATA_W-1:0] fl_rdata,
  input  logic              cfg_we,
  input  logic              cfg_force_on,
  input  logic              cfg_force_off,
  input  logic [EVT_W-1:0]  inv_evt,
  output logic              pf_active
);
  localparam int WW    = $clog2(LINE_WORDS);
  localparam int IW    = $clog2(NUM_BUF);
  localparam int TAG_W = ADDR_W - WW;
  localparam logic [WW-1:0] EARLY_W = WW'(EARLY_IDX);
  localparam logic [WW-1:0] LAST_W  = WW'(LINE_WORDS - 1);

  pfb_state_e        state_q, state_n;
  logic [WW-1:0]     cnt_q, cnt_n, tgt_q, tgt_n;
  logic [IW-1:0]     fbuf_q, fbuf_n;
  logic [TAG_W-1:0]  tag_q, tag_n;
  logic              pf_q, pf_n, kill_q, kill_n, issue_q, issue_n;
  logic              en_q, en_n, pon_q, pon_n, poff_q, poff_n;
  logic              rdy_q, rdy_n;
  logic [DATA_W-1:0] rdata_q, rdata_n;

  logic [TAG_W-1:0]  cpu_tag, nx_tag, alloc_tag;
  logic [WW-1:0]     cpu_word;
  logic              inv_all, hit, nx_hit, can_hit;
  logic [IW-1:0]     hit_buf, victim, touch_idx;
  logic [DATA_W-1:0] hit_data;
  logic              touch_en, alloc_en, wr_en, seal_en, pon_w, poff_w;

  assign cpu_tag  = cpu_addr[ADDR_W-1:WW];
  assign cpu_word = cpu_addr[WW-1:0];
  assign nx_tag   = tag_q + TAG_W'(1);
  assign inv_all  = cfg_we | (|inv_evt);
  assign wr_en    = (state_q == S_FILL) && fl_rvalid;
  assign seal_en  = wr_en && (cnt_q == LAST_W) && !kill_q;
  assign can_hit  = cpu_valid && !rdy_q && en_q && hit &&
                    ((state_q == S_IDLE) || (state_q == S_FILL && pf_q));

  pfb_lru #(.NUM_BUF(NUM_BUF)) i_lru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en),
    .touch_idx(touch_idx), .victim(victim)
  );

  pfb_line_store #(
    .NUM_BUF(NUM_BUF), .WORDS(LINE_WORDS), .DATA_W(DATA_W), .TAG_W(TAG_W)
  ) i_store (
    .clk(clk), .rst_n(rst_n),
    .lk_tag(cpu_tag), .lk_word(cpu_word), .nx_tag(nx_tag),
    .wr_en(wr_en), .wr_buf(fbuf_q), .wr_word(cnt_q), .wr_data(fl_rdata),
    .alloc_en(alloc_en), .alloc_buf(victim), .alloc_tag(alloc_tag),
    .seal_en(seal_en), .seal_buf(fbuf_q), .inv_all(inv_all),
    .hit(hit), .hit_buf(hit_buf), .hit_data(hit_data), .nx_hit(nx_hit)
  );

  // Sequencing
  always_comb begin
    state_n = state_q;  cnt_n = cnt_q;  tgt_n = tgt_q;  fbuf_n = fbuf_q;
    tag_n = tag_q;  pf_n = pf_q;  kill_n = kill_q | inv_all;
    issue_n = 1'b0;  rdy_n = 1'b0;  rdata_n = rdata_q;
    touch_en = 1'b0;  touch_idx = hit_buf;  alloc_en = 1'b0;  alloc_tag = cpu_tag;
    case (state_q)
      S_IDLE: begin
        if (cpu_valid && !rdy_q) begin
          if (!en_q) begin
            state_n = S_DIR;  tag_n = cpu_tag;  tgt_n = cpu_word;  issue_n = 1'b1;
          end else if (hit) begin
            rdy_n = 1'b1;  rdata_n = hit_data;  touch_en = 1'b1;  tag_n = cpu_tag;
            if (cpu_word >= EARLY_W) state_n = S_ARM;
          end else begin
            state_n = S_FILL;  tag_n = cpu_tag;  tgt_n = cpu_word;  cnt_n = '0;
            pf_n = 1'b0;  kill_n = 1'b0;  fbuf_n = victim;  alloc_en = 1'b1;
            touch_en = 1'b1;  touch_idx = victim;  issue_n = 1'b1;
          end
        end
      end
      S_ARM: begin
        if (en_q && !nx_hit) begin
          state_n = S_FILL;  tag_n = nx_tag;  cnt_n = '0;  pf_n = 1'b1;
          kill_n = 1'b0;  fbuf_n = victim;  alloc_en = 1'b1;  alloc_tag = nx_tag;
          touch_en = 1'b1;  touch_idx = victim;  issue_n = 1'b1;
        end else begin
          state_n = S_IDLE;
        end
      end
      S_FILL: begin
        if (can_hit) begin
          rdy_n = 1'b1;  rdata_n = hit_data;  touch_en = 1'b1;
        end
        if (fl_rvalid) begin
          if (!pf_q && cnt_q == tgt_q) begin
            rdy_n = 1'b1;  rdata_n = fl_rdata;
          end
          if (cnt_q == LAST_W) begin
            state_n = (!pf_q && tgt_q >= EARLY_W) ? S_ARM : S_IDLE;
          end else begin
            cnt_n = cnt_q + WW'(1);  issue_n = 1'b1;
          end
        end
      end
      S_DIR: begin
        if (fl_rvalid) begin
          rdy_n = 1'b1;  rdata_n = fl_rdata;  state_n = S_IDLE;
        end
      end
      default: state_n = S_IDLE;
    endcase
  end

  // Enable control: pending force bits take effect only when idle.
  always_comb begin
    pon_w  = cfg_we ? (cfg_force_on & ~cfg_force_off) : pon_q;
    poff_w = cfg_we ? cfg_force_off : poff_q;
    if (state_q == S_IDLE) begin
      en_n   = poff_w ? 1'b0 : (pon_w ? 1'b1 : en_q);
      pon_n  = 1'b0;
      poff_n = 1'b0;
    end else begin
      en_n   = en_q;
      pon_n  = pon_w;
      poff_n = poff_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;  cnt_q <= '0;  tgt_q <= '0;  fbuf_q <= '0;  tag_q <= '0;
      pf_q <= 1'b0;  kill_q <= 1'b0;  issue_q <= 1'b0;
      en_q <= EN_AT_RESET;  pon_q <= 1'b0;  poff_q <= 1'b0;
      rdy_q <= 1'b0;  rdata_q <= '0;
    end else begin
      state_q <= state_n;  cnt_q <= cnt_n;  tgt_q <= tgt_n;  fbuf_q <= fbuf_n;
      tag_q <= tag_n;  pf_q <= pf_n;  kill_q <= kill_n;  issue_q <= issue_n;
      en_q <= en_n;  pon_q <= pon_n;  poff_q <= poff_n;
      rdy_q <= rdy_n;
      if (rdy_n) rdata_q <= rdata_n;
    end
  end

  assign cpu_ready = rdy_q;
  assign cpu_rdata = rdata_q;
  assign fl_rd     = issue_q;
  assign fl_addr   = {tag_q, (state_q == S_DIR) ? tgt_q : cnt_q};
  assign pf_active = en_q;

  // R2
  hit_no_flash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && cpu_valid && !rdy_q && en_q && hit) |=> (cpu_ready && !fl_rd));
  // R2
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |=> !cpu_ready);
  // R3
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |=> !fl_rd);
  // R9
  en_hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != S_IDLE) |=> $stable(en_q));
endmodule

// File: tb/test_pfb_flash_prefetch.sv
module test_pfb_flash_prefetch;
  localparam int CLK_NS = 10;
  localparam int LAT    = 3;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int SETTLE = 16 * (LAT + 1) + 10;

  logic clk, rst_n, cpu_valid, cpu_ready, fl_rd, fl_rvalid;
  logic cfg_we, cfg_force_on, cfg_force_off, pf_active;
  logic [ADDR_W-1:0] cpu_addr, fl_addr;
  logic [DATA_W-1:0] cpu_rdata, fl_rdata;
  logic [3:0] inv_evt;

  int checks = 0, failures = 0, fl_cnt = 0;
  bit done = 0;

  pfb_flash_prefetch i_pfb_flash_prefetch (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .fl_rd(fl_rd), .fl_addr(fl_addr),
    .fl_rvalid(fl_rvalid), .fl_rdata(fl_rdata), .cfg_we(cfg_we),
    .cfg_force_on(cfg_force_on), .cfg_force_off(cfg_force_off),
    .inv_evt(inv_evt), .pf_active(pf_active)
  );

  initial clk = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] fdat(input logic [ADDR_W-1:0] a);
    return {a, ~a} ^ 32'h5A5A_0000;
  endfunction

  function automatic int miss_lat(input int k);
    return (k + 1) * (LAT + 1) + 1;
  endfunction

  function automatic logic [ADDR_W-1:0] wa(input int line, input int word);
    return ADDR_W'(line * 8 + word);
  endfunction

  // Flash model: fixed latency pipe
  logic [LAT-1:0]    pv;
  logic [ADDR_W-1:0] pa [LAT];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      for (int i = 0; i < LAT; i++) pa[i] <= '0;
    end else begin
      pv <= {pv[LAT-2:0], fl_rd};
      pa[0] <= fl_addr;
      for (int i = 1; i < LAT; i++) pa[i] <= pa[i-1];
      if (fl_rd) fl_cnt <= fl_cnt + 1;
    end
  end
  assign fl_rvalid = pv[LAT-1];
  assign fl_rdata  = fdat(pa[LAT-1]);

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic fetch(input logic [ADDR_W-1:0] a, output int lat, output logic [DATA_W-1:0] d);
    @(negedge clk);
    cpu_valid = 1'b1;
    cpu_addr  = a;
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!cpu_ready && lat < 3000);
    d = cpu_rdata;
    cpu_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic cfg_write(input logic on, input logic off);
    @(negedge clk);
    cfg_we = 1'b1; cfg_force_on = on; cfg_force_off = off;
    @(negedge clk);
    cfg_we = 1'b0; cfg_force_on = 1'b0; cfg_force_off = 1'b0;
  endtask

  task automatic pulse_evt(input int b);
    @(negedge clk);
    inv_evt[b] = 1'b1;
    @(negedge clk);
    inv_evt = '0;
  endtask

  task automatic t_reset();
    chk("R1", "pf_active", pf_active, 1);
    chk("R1", "cpu_ready", cpu_ready, 0);
    chk("R1", "fl_rd", fl_rd, 0);
  endtask

  task automatic t_miss_hit();
    int lat, f0; logic [DATA_W-1:0] d;
    f0 = fl_cnt;
    fetch(wa(2, 1), lat, d);   // R1: first fetch must miss
    chk("R3", "miss latency", lat, miss_lat(1));
    chk("R3", "miss data", d, fdat(wa(2, 1)));
    fetch(wa(2, 2), lat, d);   // waits for the line to complete
    chk("R3", "data after fill", d, fdat(wa(2, 2)));
    settle();
    chk("R3", "reads per line", fl_cnt - f0, 8);
    f0 = fl_cnt;
    fetch(wa(2, 0), lat, d);
    chk("R2", "hit latency", lat, 1);
    chk("R2", "hit data", d, fdat(wa(2, 0)));
    chk("R2", "hit flash reads", fl_cnt - f0, 0);
  endtask

  task automatic t_early_on_hit();
    int lat, f0; logic [DATA_W-1:0] d;
    f0 = fl_cnt;
    fetch(wa(2, 5), lat, d);
    chk("R4", "late-word hit latency", lat, 1);
    settle();
    chk("R4", "next line reads", fl_cnt - f0, 8);
    fetch(wa(3, 0), lat, d);
    chk("R4", "prefetched line hit", lat, 1);
    chk("R4", "prefetched data", d, fdat(wa(3, 0)));
  endtask

  task automatic t_no_early();
    int lat; logic [DATA_W-1:0] d;
    fetch(wa(10, 2), lat, d);
    settle();
    fetch(wa(11, 0), lat, d);
    chk("R4", "word 2 gives no next fill", lat, miss_lat(0));
    settle();
  endtask

  task automatic t_early_on_miss();
    int lat; logic [DATA_W-1:0] d;
    fetch(wa(20, 6), lat, d);
    chk("R3", "word 6 miss latency", lat, miss_lat(6));
    settle();
    fetch(wa(21, 0), lat, d);
    chk("R4", "next line after miss", lat, 1);
  endtask

  task automatic t_stream();
    int lat, f0; logic [DATA_W-1:0] d;
    f0 = fl_cnt;
    fetch(wa(30, 3), lat, d);
    chk("R3", "word 3 miss latency", lat, miss_lat(3));
    fetch(wa(30, 7), lat, d);
    chk("R5", "word 7 data", d, fdat(wa(30, 7)));
    fetch(wa(31, 0), lat, d);
    chk("R5", "word 0 next line waits", (lat > 1) ? 1 : 0, 1);
    chk("R5", "word 0 next line data", d, fdat(wa(31, 0)));
    settle();
    chk("R5", "no extra reads", fl_cnt - f0, 16);
  endtask

  task automatic t_lru();
    int lat; logic [DATA_W-1:0] d;
    for (int l = 100; l < 104; l++) fetch(wa(l, 0), lat, d);
    settle();
    fetch(wa(100, 0), lat, d);
    chk("R6", "touch oldest", lat, 1);
    fetch(wa(104, 0), lat, d);
    settle();
    fetch(wa(100, 0), lat, d);  chk("R6", "line 100 kept", lat, 1);
    fetch(wa(102, 0), lat, d);  chk("R6", "line 102 kept", lat, 1);
    fetch(wa(103, 0), lat, d);  chk("R6", "line 103 kept", lat, 1);
    fetch(wa(104, 0), lat, d);  chk("R6", "line 104 present", lat, 1);
    fetch(wa(101, 0), lat, d);  chk("R6", "line 101 evicted", lat, miss_lat(0));
    settle();
  endtask

  task automatic t_invalidate();
    int lat; logic [DATA_W-1:0] d;
    fetch(wa(50, 0), lat, d);
    settle();
    for (int k = 0; k < 5; k++) begin
      fetch(wa(50, 1), lat, d);
      chk(k < 4 ? "R8" : "R7", "hit before invalidate", lat, 1);
      if (k < 4) pulse_evt(k);
      else       cfg_write(1'b0, 1'b0);
      fetch(wa(50, 1), lat, d);
      chk(k < 4 ? "R8" : "R7", "miss after invalidate", lat, miss_lat(1));
      settle();
    end
  endtask

  task automatic t_kill();
    int lat; logic [DATA_W-1:0] d;
    fetch(wa(60, 0), lat, d);
    pulse_evt(2);
    settle();
    fetch(wa(60, 1), lat, d);
    chk("R7", "killed fill not valid", lat, miss_lat(1));
    chk("R7", "refill data", d, fdat(wa(60, 1)));
    settle();
  endtask

  task automatic t_defer_and_disable();
    int lat, f0; logic [DATA_W-1:0] d;
    fetch(wa(70, 0), lat, d);
    cfg_write(1'b0, 1'b1);
    chk("R9", "enable held during fill", pf_active, 1);
    settle();
    chk("R9", "disable after fill", pf_active, 0);
    f0 = fl_cnt;
    fetch(wa(70, 5), lat, d);
    chk("R10", "direct latency", lat, LAT + 2);
    chk("R10", "direct data", d, fdat(wa(70, 5)));
    fetch(wa(70, 5), lat, d);
    chk("R10", "repeat direct latency", lat, LAT + 2);
    repeat (4) @(negedge clk);
    chk("R10", "one read per fetch", fl_cnt - f0, 2);
    cfg_write(1'b1, 1'b0);
    chk("R9", "enable when idle", pf_active, 1);
    fetch(wa(70, 5), lat, d);
    chk("R10", "nothing loaded while off", lat, miss_lat(5));
    settle();
    cfg_write(1'b1, 1'b1);
    chk("R9", "off wins over on", pf_active, 0);
    cfg_write(1'b1, 1'b0);
    chk("R9", "re-enable", pf_active, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cpu_valid = 1'b0; cpu_addr = '0;
    cfg_we = 1'b0; cfg_force_on = 1'b0; cfg_force_off = 1'b0; inv_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_early_on_hit();
    t_no_early();
    t_early_on_miss();
    t_stream();
    t_lru();
    t_invalidate();
    t_kill();
    t_defer_and_disable();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule